// File: doc/BRIEF.md
# Multicore Barrier and Wake Controller

This controller sits beside a group of NC processor cores and carries out their cooperation instructions in hardware. Each core has a run flag that gates its execution. A core that executes the barrier instruction clears its own flag and stops. Once every flag is clear, the controller sets all flags again in the next cycle and the whole group resumes together. Every core has to take part in the barrier, so a core that has no work must still execute it.

The controller also tracks which cores are asleep in wait-for-interrupt. A core can send an interrupt to any other core by number. The interrupt becomes a one-cycle int0 wake pulse on the target only if that target is asleep at that moment. Otherwise it is dropped and nothing is remembered. Each core also gets a constant index output, which its core-id instruction writes into a register.

Top module: `barrier_wake_ctrl`

## Requirements
- R1: A sync request from core k whose run flag is set clears runEn[k] at the next clock edge, unless a release is under way in that cycle.
- R2: When all run flags are clear, every bit of runEn is set again at the next clock edge.
- R3: Sync requests from several cores in one cycle are all recorded in that cycle. While at least one flag is still set, no flag rises again, so a partial group is never released.
- R4: An interrupt request aimed at a sleeping core produces a single-cycle pulse on that core's int0Wake one edge later, and that core's wfiSleep bit clears at the same edge.
- R5: An interrupt request aimed at a core that is not sleeping produces no pulse and is not kept. A wait-for-interrupt executed later by that core still sleeps.
- R6: Two or more cores targeting the same sleeping core in one cycle produce exactly one int0Wake pulse on it.
- R7: A target index of NC or above is discarded. It wakes no core, including a core whose index equals the low bits of the target value.
- R8: A wait-for-interrupt request from core k sets wfiSleep[k] at the next clock edge.
- R9: The coreIdx field of core k, bits [k*IDW +: IDW] with IDW = clog2(NC), holds the value k at all times.
- R10: While rstN is low, and straight after it rises, runEn is all ones and wfiSleep and int0Wake are all zeros.
- R11: A sync request from a core whose run flag is already clear, or one arriving in the cycle of a release, has no effect on runEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncReq | input | NC | Per-core barrier instruction strobe |
| wfiReq | input | NC | Per-core wait-for-interrupt strobe |
| intxValid | input | NC | Per-core inter-core interrupt strobe |
| intxTarget | input | NC*TGTW | Target index of each core's interrupt request, core k at [k*TGTW +: TGTW], TGTW = clog2(NC)+1 |
| runEn | output | NC | Per-core run flag (execution enable) |
| int0Wake | output | NC | Per-core int0 wake pulse |
| wfiSleep | output | NC | Per-core asleep-in-wait-for-interrupt status |
| coreIdx | output | NC*IDW | Constant index of each core, core k at [k*IDW +: IDW] |

## Verification
The barrier is exercised in three ways. Cores arrive one at a time, which shows that a partial group stays held. The last cores arrive together, which shows that same-cycle requests are collected and followed by a release on the next edge. All cores arrive in one cycle, followed by a late request during the release, which shows that the release takes precedence. The wake path is driven with a sleeping target, an awake target, two senders on one target, and an out-of-range index whose low bits alias a sleeping core. These cases separate a correct gating on sleep state from stored, duplicated or aliased interrupts.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  // strobes from the control half to the register half
  typedef struct packed {
    logic releaseAll;   // every run flag is clear: set them all
    logic captureSync;  // sync requests may clear flags this cycle
  } bwcStrobe_t;
endpackage

// File: rtl/bwc_ctrl.sv
module bwc_ctrl
  import bwc_pkg::*;
#(
  parameter int NC   = 4,
  parameter int TGTW = $clog2(NC) + 1
) (
  input  logic [NC-1:0]      runFlag,
  input  logic [NC-1:0]      sleepFlag,
  input  logic [NC-1:0]      syncReq,
  input  logic [NC-1:0]      intxValid,
  input  logic [NC*TGTW-1:0] intxTarget,
  output bwcStrobe_t         strobe,
  output logic [NC-1:0]      syncClr,
  output logic [NC-1:0]      wakeHit
);
  always_comb begin
    strobe.releaseAll  = (runFlag == '0);
    strobe.captureSync = ~strobe.releaseAll;
    syncClr = strobe.captureSync ? (syncReq & runFlag) : '0;
  end

  // one wake decision per target, OR-ing every sender aimed at it
  for (genvar t = 0; t < NC; t++) begin : g_target
    logic aimed;
    always_comb begin
      aimed = 1'b0;
      for (int s = 0; s < NC; s++) begin
        if (intxValid[s] && (intxTarget[s*TGTW +: TGTW] == TGTW'(t)))
          aimed = 1'b1;
      end
      wakeHit[t] = aimed & sleepFlag[t];
    end
  end
endmodule

// File: rtl/bwc_datapath.sv
module bwc_datapath
  import bwc_pkg::*;
#(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  bwcStrobe_t    strobe,
  input  logic [NC-1:0] syncClr,
  input  logic [NC-1:0] wakeHit,
  input  logic [NC-1:0] wfiReq,
  output logic [NC-1:0] runFlag,
  output logic [NC-1:0] sleepFlag,
  output logic [NC-1:0] wakePulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag   <= '1;
      sleepFlag <= '0;
      wakePulse <= '0;
    end else begin
      runFlag   <= strobe.releaseAll ? '1 : (runFlag & ~syncClr);
      sleepFlag <= (sleepFlag & ~wakeHit) | wfiReq;
      wakePulse <= wakeHit;
    end
  end
endmodule

// File: rtl/barrier_wake_ctrl.sv
module barrier_wake_ctrl
  import bwc_pkg::*;
#(
  parameter int NC   = 4,
  parameter int IDW  = (NC > 1) ? $clog2(NC) : 1,
  parameter int TGTW = $clog2(NC) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NC-1:0]      syncReq,
  input  logic [NC-1:0]      wfiReq,
  input  logic [NC-1:0]      intxValid,
  input  logic [NC*TGTW-1:0] intxTarget,
  output logic [NC-1:0]      runEn,
  output logic [NC-1:0]      int0Wake,
  output logic [NC-1:0]      wfiSleep,
  output logic [NC*IDW-1:0]  coreIdx
);
  bwcStrobe_t    strobe;
  logic [NC-1:0] syncClr;
  logic [NC-1:0] wakeHit;

  bwc_ctrl #(.NC(NC), .TGTW(TGTW)) i_ctrl (
    .runFlag   (runEn),
    .sleepFlag (wfiSleep),
    .syncReq   (syncReq),
    .intxValid (intxValid),
    .intxTarget(intxTarget),
    .strobe    (strobe),
    .syncClr   (syncClr),
    .wakeHit   (wakeHit)
  );

  bwc_datapath #(.NC(NC)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .syncClr  (syncClr),
    .wakeHit  (wakeHit),
    .wfiReq   (wfiReq),
    .runFlag  (runEn),
    .sleepFlag(wfiSleep),
    .wakePulse(int0Wake)
  );

  for (genvar k = 0; k < NC; k++) begin : g_cid
    assign coreIdx[k*IDW +: IDW] = IDW'(k);
  end
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic [NC-1:0] syncReq,
  input logic [NC-1:0] wfiReq,
  input logic [NC-1:0] runEn,
  input logic [NC-1:0] int0Wake,
  input logic [NC-1:0] wfiSleep
);
  p_sync_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    (((syncReq & runEn) != '0) && (runEn != '0)) |=> ((runEn & $past(syncReq)) == '0));

  p_release_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runEn == '0) |=> (&runEn));

  p_no_partial_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runEn != '0) |=> ((runEn & ~$past(runEn)) == '0));

  p_wake_clears_sleep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (int0Wake != '0) |-> ((int0Wake & wfiSleep & ~$past(wfiReq)) == '0));

  p_wake_needs_sleep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int0Wake != '0) |-> ((int0Wake & ~$past(wfiSleep)) == '0));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int0Wake != '0) |=> ((int0Wake & $past(int0Wake)) == '0));

  p_wfi_sets_sleep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wfiReq != '0) |=> ((wfiSleep & $past(wfiReq)) == $past(wfiReq)));
endmodule

bind barrier_wake_ctrl bwc_checker #(.NC(NC)) i_bwc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .syncReq (syncReq),
  .wfiReq  (wfiReq),
  .runEn   (runEn),
  .int0Wake(int0Wake),
  .wfiSleep(wfiSleep)
);

// File: tb/test_barrier_wake_ctrl.sv
module test_barrier_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC   = 4;
  localparam int IDW  = 2;
  localparam int TGTW = 3;
  localparam int NV   = 17;

  typedef struct packed {
    logic [NC-1:0]      sy;
    logic [NC-1:0]      wf;
    logic [NC-1:0]      iv;
    logic [NC*TGTW-1:0] tg;
    logic [NC-1:0]      eRun;
    logic [NC-1:0]      eSlp;
    logic [NC-1:0]      eInt;
  } vec_t;

  // applied one per cycle; expectations are the outputs after that edge
  localparam vec_t VECS [0:NV-1] = '{
    '{4'b0000, 4'b0001, 4'b0000, 12'h000, 4'b1111, 4'b0001, 4'b0000}, // R8 core0 sleeps
    '{4'b0000, 4'b0000, 4'b0010, 12'h000, 4'b1111, 4'b0000, 4'b0001}, // R4 core1 wakes core0
    '{4'b0000, 4'b0000, 4'b0000, 12'h000, 4'b1111, 4'b0000, 4'b0000}, // R4 pulse ends
    '{4'b0000, 4'b0000, 4'b0100, 12'h0C0, 4'b1111, 4'b0000, 4'b0000}, // R5 core3 awake
    '{4'b0000, 4'b1000, 4'b0000, 12'h000, 4'b1111, 4'b1000, 4'b0000}, // R5 nothing pending
    '{4'b0000, 4'b0000, 4'b0011, 12'h01B, 4'b1111, 4'b0000, 4'b1000}, // R6 two senders
    '{4'b0000, 4'b0000, 4'b0000, 12'h000, 4'b1111, 4'b0000, 4'b0000}, // R6 single pulse
    '{4'b0000, 4'b0100, 4'b0000, 12'h000, 4'b1111, 4'b0100, 4'b0000}, // R8 core2 sleeps
    '{4'b0000, 4'b0000, 4'b0001, 12'h006, 4'b1111, 4'b0100, 4'b0000}, // R7 index 6 aliases 2
    '{4'b0000, 4'b0000, 4'b0010, 12'h010, 4'b1111, 4'b0000, 4'b0100}, // R4 wake core2
    '{4'b0001, 4'b0000, 4'b0000, 12'h000, 4'b1110, 4'b0000, 4'b0000}, // R1 core0 sync
    '{4'b0011, 4'b0000, 4'b0000, 12'h000, 4'b1100, 4'b0000, 4'b0000}, // R11 repeat + R1
    '{4'b0000, 4'b0000, 4'b0000, 12'h000, 4'b1100, 4'b0000, 4'b0000}, // R3 partial held
    '{4'b1100, 4'b0000, 4'b0000, 12'h000, 4'b0000, 4'b0000, 4'b0000}, // R3 last two together
    '{4'b0000, 4'b0000, 4'b0000, 12'h000, 4'b1111, 4'b0000, 4'b0000}, // R2 release
    '{4'b1111, 4'b0000, 4'b0000, 12'h000, 4'b0000, 4'b0000, 4'b0000}, // R3 all at once
    '{4'b0001, 4'b0000, 4'b0000, 12'h000, 4'b1111, 4'b0000, 4'b0000}  // R11 sync in release
  };

  function automatic string vecTag(int i);
    case (i)
      0, 7:          return "R8";
      1, 2, 9:       return "R4";
      3, 4:          return "R5";
      5, 6:          return "R6";
      8:             return "R7";
      10:            return "R1";
      11, 16:        return "R11";
      12, 13, 15:    return "R3";
      default:       return "R2";
    endcase
  endfunction

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NC-1:0]      syncReq = '0;
  logic [NC-1:0]      wfiReq = '0;
  logic [NC-1:0]      intxValid = '0;
  logic [NC*TGTW-1:0] intxTarget = '0;
  logic [NC-1:0]      runEn;
  logic [NC-1:0]      int0Wake;
  logic [NC-1:0]      wfiSleep;
  logic [NC*IDW-1:0]  coreIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrier_wake_ctrl #(.NC(NC)) i_barrier_wake_ctrl (
    .clk(clk), .rstN(rstN), .syncReq(syncReq), .wfiReq(wfiReq),
    .intxValid(intxValid), .intxTarget(intxTarget), .runEn(runEn),
    .int0Wake(int0Wake), .wfiSleep(wfiSleep), .coreIdx(coreIdx)
  );

  task automatic checkOut(string tag, logic [NC-1:0] eRun, logic [NC-1:0] eSlp,
                          logic [NC-1:0] eInt);
    nChecks++;
    if (runEn !== eRun || wfiSleep !== eSlp || int0Wake !== eInt) begin
      nFails++;
      $display("FAIL %s: run/sleep/int0 = %b/%b/%b, expected %b/%b/%b",
               tag, runEn, wfiSleep, int0Wake, eRun, eSlp, eInt);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R10 during reset", 4'b1111, 4'b0000, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R10 after reset", 4'b1111, 4'b0000, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      syncReq    = VECS[i].sy;
      wfiReq     = VECS[i].wf;
      intxValid  = VECS[i].iv;
      intxTarget = VECS[i].tg;
      @(negedge clk);
      checkOut(vecTag(i), VECS[i].eRun, VECS[i].eSlp, VECS[i].eInt);
    end
    syncReq = '0; wfiReq = '0; intxValid = '0; intxTarget = '0;

    // R9: constant core indices
    for (int k = 0; k < NC; k++) begin
      nChecks++;
      if (coreIdx[k*IDW +: IDW] !== IDW'(k)) begin
        nFails++;
        $display("FAIL R9: core %0d index %0d, expected %0d",
                 k, coreIdx[k*IDW +: IDW], k);
      end
    end

    // R10: reset in the middle of a barrier and a sleep
    syncReq = 4'b0011; wfiReq = 4'b0100;
    @(negedge clk);
    syncReq = '0; wfiReq = '0;
    checkOut("R1 before mid reset", 4'b1100, 4'b0100, 4'b0000);
    rstN = 1'b0;
    #1;
    checkOut("R10 mid-run reset", 4'b1111, 4'b0000, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: a wake sent to an awake core after reset leaves nothing behind
    intxValid = 4'b0001; intxTarget = 12'h001;
    @(negedge clk);
    intxValid = '0; intxTarget = '0;
    checkOut("R5 after reset", 4'b1111, 4'b0000, 4'b0000);
    report();
  end

  initial begin
    repeat (2000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end
endmodule